// File: doc/BRIEF.md
# Rate-Limited Field Duty Ramp Controller

This block sits between a requested field duty code and the final gate PWM bit. The requested code comes from an analog stage upstream. The output duty follows the request, but it moves by only one sixteenth of full scale at a time, and consecutive moves are spaced by a fixed rate interval. The interval is built from a base prescaler and a divide factor. The divide factor drops from a slow value to 4 while the engine-speed flag is high, so the duty tracks faster at speed.

A rising edge on the ignition input puts the block into a start-up mode. In this mode the duty is loaded with the minimum limited value (code 5, 31.25%). From there it ramps at the limited rate and is never allowed to fall below that floor, whatever the request. Start-up mode ends as soon as the supply-recovered flag is high, and normal limited tracking resumes. A 16-slot counter turns the limited duty code into the PWM bit.

Top module: `duty_ramp_ctrl`

## Requirements
- R1: While reset is high, and on the first edge after it, the duty code is 0, the PWM bit is low and start-up mode is clear.
- R2: In normal mode, on each rate step the duty moves by exactly one code toward the effective request. It stops on the request and holds it, with no overshoot when rising and no undershoot when falling.
- R3: With the speed flag low, duty changes made by consecutive rate steps are exactly BASE_CYC*N_SLOW clock cycles apart.
- R4: With the speed flag high, the divide factor is 4, so consecutive rate-step changes are BASE_CYC*N_FAST cycles apart.
- R5: On the first edge that sees ignition high after it was low, the duty code becomes 5, start-up mode is entered and the rate timing restarts from zero.
- R6: In start-up mode, the duty ramps at the limited rate toward the request, but a request below 5 is treated as 5, so the duty stays at 5 or above.
- R7: Start-up mode ends on the edge after the supply-recovered flag is seen high. Afterwards the duty may ramp below 5 to a lower request.
- R8: A request code above 16 is treated as 16.
- R9: While ignition is low, the duty code is forced to 0 on the next edge and start-up mode is cleared.
- R10: PWM: over any 16 consecutive cycles at a steady duty code d, the PWM bit is high for exactly d cycles. Code 16 gives a constant high and code 0 a constant low. The PWM bit follows the duty code with one register of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ign_on_i | input | 1 | Ignition on level; a rising edge enters start-up mode |
| supply_ok_i | input | 1 | Supply voltage has recovered; ends start-up mode |
| speed_hi_i | input | 1 | Engine speed above threshold; selects the short divide factor |
| req_duty_i | input | DUTY_W | Requested duty in sixteenths (0..16, larger values saturate) |
| duty_o | output | DUTY_W | Rate-limited duty code |
| pwm_o | output | 1 | Gate PWM bit |

## Verification
The hardest state to reach is start-up mode holding at its floor while the request sits below the floor, followed by the release when the supply recovers. The stimulus first ramps the duty to full scale in start-up mode. It then drops the request to 2 with the supply flag still low and watches the duty descend to 5 and stay there for several intervals. Only then does it raise the supply flag and expect 4, 3 and 2. A scoreboard queue holds every expected duty value in order and times the gap between successive steps, so a step taken early, late, doubled or missed all show up as mismatches.

// File: rtl/duty_ramp_pkg.sv
package duty_ramp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_START = 2'd1,
    MODE_NORM  = 2'd2
  } ramp_mode_e;

endpackage

// File: rtl/rate_tick_gen.sv
module rate_tick_gen #(
  parameter int BASE_CYC = 125000,
  parameter int N_SLOW   = 8,
  parameter int N_FAST   = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic fast,
  output logic step_tick
);
  localparam int NMAX   = (N_SLOW > N_FAST) ? N_SLOW : N_FAST;
  localparam int BASE_W = (BASE_CYC > 2) ? $clog2(BASE_CYC) : 1;
  localparam int DIV_W  = $clog2(NMAX + 1);

  logic [BASE_W-1:0] base_cnt;
  logic [DIV_W-1:0]  div_cnt;
  logic [DIV_W-1:0]  div_last;
  logic              base_hit;
  logic              div_hit;

  assign base_hit = (base_cnt == BASE_W'(BASE_CYC - 1));
  assign div_last = fast ? DIV_W'(N_FAST - 1) : DIV_W'(N_SLOW - 1);
  // >= lets a switch to the short factor mid-interval step at once
  assign div_hit  = (div_cnt >= div_last);
  assign step_tick = base_hit && div_hit;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      base_cnt <= '0;
    end else if (base_hit) begin
      base_cnt <= '0;
    end else begin
      base_cnt <= base_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_cnt <= '0;
    end else if (base_hit) begin
      if (div_hit) begin
        div_cnt <= '0;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
  import duty_ramp_pkg::*;
#(
  parameter int FULL     = 16,
  parameter int MIN_DUTY = 5,
  parameter int DUTY_W   = $clog2(FULL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ign_on,
  input  logic              ign_rise,
  input  logic              supply_ok,
  input  logic              step_tick,
  input  logic [DUTY_W-1:0] req_duty,
  output logic [DUTY_W-1:0] duty,
  output logic [DUTY_W-1:0] tgt,
  output logic              in_start
);
  localparam logic [DUTY_W-1:0] FULL_C = DUTY_W'(FULL);
  localparam logic [DUTY_W-1:0] MIN_C  = DUTY_W'(MIN_DUTY);

  ramp_mode_e        mode_q;
  logic [DUTY_W-1:0] req_sat;

  assign in_start = (mode_q == MODE_START);
  assign req_sat  = (req_duty > FULL_C) ? FULL_C : req_duty;
  assign tgt      = (in_start && (req_sat < MIN_C)) ? MIN_C : req_sat;

  always_ff @(posedge clk) begin
    if (rst || !ign_on) begin
      mode_q <= MODE_OFF;
    end else if (ign_rise) begin
      mode_q <= MODE_START;
    end else if (in_start && supply_ok) begin
      mode_q <= MODE_NORM;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !ign_on) begin
      duty <= '0;
    end else if (ign_rise) begin
      duty <= MIN_C;
    end else if (step_tick) begin
      if (duty < tgt) begin
        duty <= duty + 1'b1;
      end else if (duty > tgt) begin
        duty <= duty - 1'b1;
      end
    end
  end

endmodule

// File: rtl/pwm_slicer.sv
module pwm_slicer #(
  parameter int FULL   = 16,
  parameter int DUTY_W = $clog2(FULL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DUTY_W-1:0] duty,
  output logic              pwm
);
  localparam int SLOT_W = (FULL > 2) ? $clog2(FULL) : 1;

  logic [SLOT_W-1:0] slot;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot <= '0;
    end else if (slot == SLOT_W'(FULL - 1)) begin
      slot <= '0;
    end else begin
      slot <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm <= 1'b0;
    end else begin
      pwm <= (DUTY_W'(slot) < duty);
    end
  end

endmodule

// File: rtl/duty_ramp_ctrl.sv
module duty_ramp_ctrl #(
  parameter int FULL     = 16,
  parameter int MIN_DUTY = 5,
  parameter int BASE_CYC = 125000,
  parameter int N_SLOW   = 8,
  parameter int N_FAST   = 4,
  parameter int DUTY_W   = $clog2(FULL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ign_on_i,
  input  logic              supply_ok_i,
  input  logic              speed_hi_i,
  input  logic [DUTY_W-1:0] req_duty_i,
  output logic [DUTY_W-1:0] duty_o,
  output logic              pwm_o
);
  logic              ign_q;
  logic              ign_rise;
  logic              step_tick;
  logic [DUTY_W-1:0] tgt_code;
  logic              in_start;

  always_ff @(posedge clk) begin
    if (rst) begin
      ign_q <= 1'b0;
    end else begin
      ign_q <= ign_on_i;
    end
  end

  assign ign_rise = ign_on_i && !ign_q;

  rate_tick_gen #(
    .BASE_CYC(BASE_CYC),
    .N_SLOW  (N_SLOW),
    .N_FAST  (N_FAST)
  ) u_rate (
    .clk      (clk),
    .rst      (rst),
    .restart  (ign_rise || !ign_on_i),
    .fast     (speed_hi_i),
    .step_tick(step_tick)
  );

  duty_stepper #(
    .FULL    (FULL),
    .MIN_DUTY(MIN_DUTY),
    .DUTY_W  (DUTY_W)
  ) u_step (
    .clk      (clk),
    .rst      (rst),
    .ign_on   (ign_on_i),
    .ign_rise (ign_rise),
    .supply_ok(supply_ok_i),
    .step_tick(step_tick),
    .req_duty (req_duty_i),
    .duty     (duty_o),
    .tgt      (tgt_code),
    .in_start (in_start)
  );

  pwm_slicer #(
    .FULL  (FULL),
    .DUTY_W(DUTY_W)
  ) u_pwm (
    .clk (clk),
    .rst (rst),
    .duty(duty_o),
    .pwm (pwm_o)
  );

endmodule

// File: rtl/duty_ramp_chk.sv
module duty_ramp_chk #(
  parameter int FULL     = 16,
  parameter int MIN_DUTY = 5,
  parameter int DUTY_W   = $clog2(FULL + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              ign_on_i,
  input logic              ign_rise,
  input logic              step_tick,
  input logic              in_start,
  input logic [DUTY_W-1:0] tgt_code,
  input logic [DUTY_W-1:0] duty_o,
  input logic              pwm_o
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  // R8
  duty_range_chk: assert property (@(posedge clk) disable iff (rst)
    duty_o <= DUTY_W'(FULL));

  // R2
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ign_on_i) && !$past(ign_rise)) |->
      ((duty_o == $past(duty_o)) || (duty_o == $past(duty_o) + 1'b1) ||
       (duty_o + 1'b1 == $past(duty_o))));

  // R3
  gated_change_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && (duty_o != $past(duty_o))) |->
      ($past(step_tick) || $past(ign_rise) || !$past(ign_on_i)));

  // R2
  no_overshoot_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ign_on_i) && !$past(ign_rise) && (duty_o > $past(duty_o))) |->
      (duty_o <= $past(tgt_code)));

  // R5
  ign_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(ign_rise)) |-> (duty_o == DUTY_W'(MIN_DUTY) && in_start));

  // R6
  start_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && in_start) |-> (duty_o >= DUTY_W'(MIN_DUTY)));

  // R9
  ign_off_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(ign_on_i)) |-> (duty_o == '0 && !in_start));

  // R10
  pwm_full_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(duty_o) == DUTY_W'(FULL)) |-> pwm_o);

  // R10
  pwm_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(duty_o) == '0) |-> !pwm_o);

endmodule

bind duty_ramp_ctrl duty_ramp_chk #(
  .FULL    (FULL),
  .MIN_DUTY(MIN_DUTY),
  .DUTY_W  (DUTY_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ign_on_i (ign_on_i),
  .ign_rise (ign_rise),
  .step_tick(step_tick),
  .in_start (in_start),
  .tgt_code (tgt_code),
  .duty_o   (duty_o),
  .pwm_o    (pwm_o)
);

// File: tb/sim_duty_ramp_ctrl.sv
`timescale 1ns/1ps
module sim_duty_ramp_ctrl;
  localparam int FULL = 16;
  localparam int DW   = 5;
  localparam int BASE = 4;
  localparam int NS   = 8;
  localparam int NF   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ign = 1'b0;
  logic sup = 1'b0;
  logic spd = 1'b0;
  logic [DW-1:0] req = '0;
  logic [DW-1:0] duty;
  logic pwm;

  always #5 clk = ~clk;

  duty_ramp_ctrl #(.FULL(FULL), .MIN_DUTY(5), .BASE_CYC(BASE),
                   .N_SLOW(NS), .N_FAST(NF)) u0 (
    .clk(clk), .rst(rst), .ign_on_i(ign), .supply_ok_i(sup),
    .speed_hi_i(spd), .req_duty_i(req), .duty_o(duty), .pwm_o(pwm));

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int exp_q[$];
  string tag_q[$];
  int gap_exp  = 0;
  bit skip_gap = 1'b1;
  bit mon_en   = 1'b0;
  int last_cyc = 0;
  logic [DW-1:0] last_duty = '0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string rq, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every duty change, times the steps
  always @(negedge clk) begin
    if (mon_en && duty !== last_duty) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2", int'(duty), int'(last_duty), "unexpected duty change");
      end else begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(duty) == e, t, int'(duty), e, "duty value");
        if (!skip_gap && gap_exp != 0)
          check(cyc - last_cyc == gap_exp, (gap_exp == BASE*NS) ? "R3" : "R4",
                cyc - last_cyc, gap_exp, "step spacing");
      end
      skip_gap = 1'b0;
      last_cyc = cyc;
      last_duty = duty;
    end
  end

  task automatic push_ramp(input int from, input int to, input string t);
    if (from <= to) for (int v = from; v <= to; v++) begin exp_q.push_back(v); tag_q.push_back(t); end
    else            for (int v = from; v >= to; v--) begin exp_q.push_back(v); tag_q.push_back(t); end
  endtask

  task automatic stim_edge();
    @(posedge clk); #2;
    skip_gap = 1'b1;
  endtask

  task automatic drain_hold(input int hold, input int final_v, input string t);
    while (exp_q.size() != 0) @(negedge clk);
    repeat (hold) @(negedge clk);
    check(int'(duty) == final_v, t, int'(duty), final_v, "settled duty");
  endtask

  task automatic pwm_count(input int d, input string t);
    int hi = 0;
    for (int i = 0; i < FULL; i++) begin
      @(negedge clk);
      if (pwm) hi++;
    end
    check(hi == d, t, hi, d, "PWM high cycles per 16");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(duty == '0, "R1", int'(duty), 0, "reset duty");
    check(pwm == 1'b0, "R1", int'(pwm), 0, "reset pwm");
    @(posedge clk); #2 rst = 1'b0;
    @(negedge clk);
    check(duty == '0, "R1", int'(duty), 0, "duty after reset release");
    mon_en = 1'b1;

    // Start-up ramp from the floor to full scale
    gap_exp = BASE*NS;
    stim_edge(); req = 5'd16; ign = 1'b1;
    exp_q.push_back(5); tag_q.push_back("R5");
    push_ramp(6, 16, "R6");
    drain_hold(3*BASE*NS, 16, "R6");
    pwm_count(16, "R10");

    // Request below the floor while still in start-up: hold at 5
    stim_edge(); req = 5'd2;
    push_ramp(15, 5, "R6");
    drain_hold(4*BASE*NS, 5, "R6");

    // Supply recovers: normal tracking below the floor
    stim_edge(); sup = 1'b1;
    push_ramp(4, 2, "R7");
    drain_hold(3*BASE*NS, 2, "R7");
    pwm_count(2, "R10");

    // Speed flag high: shorter interval
    gap_exp = BASE*NF;
    stim_edge(); spd = 1'b1; req = 5'd10;
    push_ramp(3, 10, "R4");
    drain_hold(3*BASE*NF, 10, "R4");
    pwm_count(10, "R10");

    // Decrease with no undershoot
    stim_edge(); req = 5'd7;
    push_ramp(9, 7, "R2");
    drain_hold(4*BASE*NF, 7, "R2");
    pwm_count(7, "R10");

    // Out-of-range request saturates at 16
    stim_edge(); req = 5'd31;
    push_ramp(8, 16, "R8");
    drain_hold(4*BASE*NF, 16, "R8");

    // Ignition off forces zero
    stim_edge(); ign = 1'b0;
    exp_q.push_back(0); tag_q.push_back("R9");
    drain_hold(2*BASE*NS, 0, "R9");
    pwm_count(0, "R10");

    // Re-entry with supply already good: floor then normal tracking down to 3
    gap_exp = BASE*NS;
    stim_edge(); spd = 1'b0; req = 5'd3; ign = 1'b1;
    exp_q.push_back(5); tag_q.push_back("R5");
    push_ramp(4, 3, "R7");
    drain_hold(3*BASE*NS, 3, "R7");

    done = 1'b1;
  end

  initial begin
    while (!done && cyc < 150000) @(posedge clk);
    if (!done) check(1'b0, "R1", cyc, 150000, "watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule